// File: doc/BRIEF.md
# Key-Protected Control Register Bank

This block is a memory-mapped bank of system control registers on a simple single-cycle read/write bus. The bus has a 12-bit byte offset and 32-bit data. Most of the bank is write-protected. Software has to present a 16-bit unlock key at a dedicated key register before any register at offset 0x100 or above accepts a write. A second key at a neighbouring register restores the protection. A status register reports the current protection state.

The bank comes out of reset protected. Three register windows hold 32-bit storage:

- 0x100–0x11C
- 0x200–0x258
- 0x600–0x620

Each window has fixed holes. A small scratch bit at offset 0x000 stays writable at all times.

A write of a set bit 0 to the reset-control register at 0x200, made while the bank is unprotected, produces a one-cycle soft-reset request. A system reset controller consumes this request.

Top module: `keyed_ctl_bank`

## Requirements
- R1: A write to offset 0x004 whose data bits [15:0] equal 0x767B sets the lock flag. Any other value written there leaves the flag unchanged.
- R2: A write to offset 0x008 whose data bits [15:0] equal 0xDF0D clears the lock flag. Bits [31:16] are ignored, and any other low half leaves the flag unchanged.
- R3: A read of offset 0x00C returns the lock flag in bit 0 and zero in bits [31:1]. Writes to 0x00C change nothing.
- R4: Reads of offsets 0x004 and 0x008 return zero.
- R5: After reset, the bank is in a fixed state, whether reset is applied at power-up or during operation:
  - the lock flag is 1;
  - soft_rst_req is low;
  - offset 0x10C reads 0x0000003F;
  - offset 0x000 reads 0;
  - every other storage register reads 0.
- R6: While the lock flag is 1, every write to an offset of 0x100 or above is discarded.
- R7: Offset 0x000 stores only bit 0 of the written data and reads it back in bit 0. It accepts writes whether the bank is locked or not.
- R8: A write to offset 0x200 made while unlocked with data bit 0 set drives soft_rst_req high for exactly the one cycle after the write edge. No pulse follows such a write when it is locked or has bit 0 clear.
- R9: Writes to offsets 0x10C, 0x250 and 0x604 change nothing. Offset 0x604 and every unmapped offset read zero.
- R10: Offset 0x25C always reads 0x00000001, and writes to it have no effect.
- R11: An access whose offset has bits [1:0] not equal to zero reads zero and changes no state, including the key registers.
- R12: When unlocked, a write to a storage offset stores all 32 bits, and the value reads back on the next access. The storage offsets are 0x100–0x11C, 0x200–0x258 and 0x600–0x620, excluding the holes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| soft_rst_req | output | 1 | One-cycle soft-reset request |

## Verification
Each result is due at a known cycle, and the bench samples at that cycle:

- **Read data.** Read data is combinational from the presented offset and the current state. The bench drives a read on the falling edge and samples one nanosecond later, before the next rising edge.
- **Writes and the lock flag.** A write takes effect on the rising edge that ends its cycle. Every write is therefore checked by a read in a later cycle.
- **Soft-reset request.** The request passes through one register. The bench samples it at the falling edge that follows the write's rising edge, and again one cycle later to confirm that the pulse has ended.

// File: rtl/kcb_pkg.sv
`timescale 1ns/1ps
package kcb_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int KEY_W  = 16;

  // fixed offsets whose behaviour is decoded individually
  localparam logic [ADDR_W-1:0] OFF_SCRATCH = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_LOCK    = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_UNLOCK  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_STATUS  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_ROSTAT  = 12'h10C;
  localparam logic [ADDR_W-1:0] OFF_RSTCTL  = 12'h200;
  localparam logic [ADDR_W-1:0] OFF_HOLE_B  = 12'h250;
  localparam logic [ADDR_W-1:0] OFF_CONST1  = 12'h25C;
  localparam logic [ADDR_W-1:0] OFF_HOLE_C  = 12'h604;

  // storage windows
  localparam int NWIN = 3;
  localparam int WIN_BASE  [NWIN] = '{'h100, 'h200, 'h600};
  localparam int WIN_WORDS [NWIN] = '{8, 23, 9};

  function automatic int win_first(int w);
    int s;
    s = 0;
    for (int k = 0; k < w; k++) s += WIN_WORDS[k];
    return s;
  endfunction

  localparam int NWORDS = win_first(NWIN);
  localparam int IDX_W  = $clog2(NWORDS);

  localparam logic [DATA_W-1:0] ROSTAT_RST = 32'h0000_003F;

  // reset value of a storage word
  function automatic logic [DATA_W-1:0] word_reset(int i);
    if (i == win_first(0) + (int'(OFF_ROSTAT) - WIN_BASE[0]) / 4)
      return ROSTAT_RST;
    return '0;
  endfunction

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_SCRATCH,
    KIND_LOCK,
    KIND_UNLOCK,
    KIND_STATUS,
    KIND_ONE,
    KIND_FILE
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [IDX_W-1:0] idx;
    logic             wr_ok;
    logic             rst_ctl;
  } dec_t;

endpackage

// File: rtl/kcb_decode.sv
`timescale 1ns/1ps
module kcb_decode
  import kcb_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);

  int off;

  always_comb begin
    off         = int'(addr);
    dec.kind    = KIND_NONE;
    dec.idx     = '0;
    dec.wr_ok   = 1'b0;
    dec.rst_ctl = 1'b0;
    if (addr[1:0] == 2'b00) begin
      for (int w = 0; w < NWIN; w++) begin
        if (off >= WIN_BASE[w] && off < WIN_BASE[w] + 4 * WIN_WORDS[w]) begin
          dec.kind  = KIND_FILE;
          dec.idx   = IDX_W'(win_first(w) + (off - WIN_BASE[w]) / 4);
          dec.wr_ok = 1'b1;
        end
      end
      case (addr)
        OFF_SCRATCH: dec.kind  = KIND_SCRATCH;
        OFF_LOCK:    dec.kind  = KIND_LOCK;
        OFF_UNLOCK:  dec.kind  = KIND_UNLOCK;
        OFF_STATUS:  dec.kind  = KIND_STATUS;
        OFF_ROSTAT:  dec.wr_ok = 1'b0;
        OFF_HOLE_B:  dec.wr_ok = 1'b0;
        OFF_CONST1: begin
          dec.kind  = KIND_ONE;
          dec.wr_ok = 1'b0;
        end
        OFF_HOLE_C: begin
          dec.kind  = KIND_NONE;
          dec.wr_ok = 1'b0;
        end
        OFF_RSTCTL:  dec.rst_ctl = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/kcb_lock.sv
`timescale 1ns/1ps
module kcb_lock
  import kcb_pkg::*;
#(
  parameter logic [KEY_W-1:0] LOCK_KEY   = 16'h767B,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hDF0D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lock,
  input  logic             wr_unlock,
  input  logic [KEY_W-1:0] key,
  output logic             locked
);

  logic lock_d;
  logic lock_en;

  always_comb begin
    lock_en = 1'b0;
    lock_d  = locked;
    if (wr_lock && key == LOCK_KEY) begin
      lock_en = 1'b1;
      lock_d  = 1'b1;
    end else if (wr_unlock && key == UNLOCK_KEY) begin
      lock_en = 1'b1;
      lock_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      locked <= 1'b1;
    else if (lock_en)
      locked <= lock_d;
  end

endmodule

// File: rtl/kcb_regfile.sv
`timescale 1ns/1ps
module kcb_regfile
  import kcb_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [IDX_W-1:0]              widx,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NWORDS-1:0][DATA_W-1:0] q
);

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    logic              en;
    logic [DATA_W-1:0] word_q;

    always_comb en = we && (widx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= word_reset(i);
      else if (en)
        word_q <= wdata;
    end

    assign q[i] = word_q;
  end

endmodule

// File: rtl/keyed_ctl_bank.sv
`timescale 1ns/1ps
module keyed_ctl_bank
  import kcb_pkg::*;
#(
  parameter logic [KEY_W-1:0] LOCK_KEY   = 16'h767B,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hDF0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              soft_rst_req
);

  dec_t                          dec;
  logic                          wr_acc;
  logic                          locked;
  logic                          file_we;
  logic [NWORDS-1:0][DATA_W-1:0] file_q;
  logic                          scratch_q;
  logic                          scratch_en;
  logic                          pulse_d;

  kcb_decode u_decode (
    .addr (bus_addr),
    .dec  (dec)
  );

  assign wr_acc = bus_sel && bus_wr;

  kcb_lock #(
    .LOCK_KEY   (LOCK_KEY),
    .UNLOCK_KEY (UNLOCK_KEY)
  ) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lock   (wr_acc && dec.kind == KIND_LOCK),
    .wr_unlock (wr_acc && dec.kind == KIND_UNLOCK),
    .key       (bus_wdata[KEY_W-1:0]),
    .locked    (locked)
  );

  assign file_we = wr_acc && !locked && dec.kind == KIND_FILE && dec.wr_ok;

  kcb_regfile u_file (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (file_we),
    .widx  (dec.idx),
    .wdata (bus_wdata),
    .q     (file_q)
  );

  // scratch bit: open regardless of lock
  assign scratch_en = wr_acc && dec.kind == KIND_SCRATCH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      scratch_q <= 1'b0;
    else if (scratch_en)
      scratch_q <= bus_wdata[0];
  end

  // soft-reset request, registered one cycle after the accepted write
  assign pulse_d = wr_acc && !locked && dec.rst_ctl && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      soft_rst_req <= 1'b0;
    else
      soft_rst_req <= pulse_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (dec.kind)
        KIND_SCRATCH: bus_rdata = {{(DATA_W-1){1'b0}}, scratch_q};
        KIND_STATUS:  bus_rdata = {{(DATA_W-1){1'b0}}, locked};
        KIND_ONE:     bus_rdata = {{(DATA_W-1){1'b0}}, 1'b1};
        KIND_FILE:    bus_rdata = file_q[dec.idx];
        default:      bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/kcb_checker.sv
`timescale 1ns/1ps
module kcb_checker
  import kcb_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_sel,
  input logic                          bus_wr,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [DATA_W-1:0]             bus_wdata,
  input logic [DATA_W-1:0]             bus_rdata,
  input logic                          soft_rst_req,
  input logic                          locked,
  input logic [NWORDS-1:0][DATA_W-1:0] file_q
);

  a_r1_lock_key: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFF_LOCK && bus_wdata[15:0] == 16'h767B)
    |=> locked);

  a_r2_unlock_key: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFF_UNLOCK && bus_wdata[15:0] == 16'hDF0D)
    |=> !locked);

  a_r3_status_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == OFF_STATUS)
    |-> bus_rdata == {{(DATA_W-1){1'b0}}, locked});

  a_r4_key_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == OFF_LOCK || bus_addr == OFF_UNLOCK))
    |-> bus_rdata == '0);

  a_r6_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(file_q));

  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |-> $past(bus_sel && bus_wr && bus_addr == OFF_RSTCTL
                           && bus_wdata[0] && !locked));

  a_r10_const_one: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == OFF_CONST1) |-> bus_rdata == 32'h1);

endmodule

bind keyed_ctl_bank kcb_checker u_kcb_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_sel      (bus_sel),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .soft_rst_req (soft_rst_req),
  .locked       (locked),
  .file_q       (file_q)
);

// File: tb/keyed_ctl_bank_bench.sv
`timescale 1ns/1ps
module keyed_ctl_bank_bench;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        soft_rst_req;

  int total;
  int bad;
  logic pulse_now;

  keyed_ctl_bank u_keyed_ctl_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .soft_rst_req (soft_rst_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {is_write, req, addr, data, expected}
  localparam int NVEC = 40;
  localparam logic [80:0] VEC [NVEC] = '{
    {1'b1, 4'd6,  12'h100, 32'hAAAA5555, 32'h0},        // R6 locked write
    {1'b0, 4'd6,  12'h100, 32'h0,        32'h0},        // R6
    {1'b1, 4'd2,  12'h008, 32'h1234DF0C, 32'h0},        // R2 wrong key
    {1'b0, 4'd2,  12'h00C, 32'h0,        32'h1},        // R2
    {1'b1, 4'd2,  12'h008, 32'hFFFFDF0D, 32'h0},        // R2 unlock
    {1'b0, 4'd3,  12'h00C, 32'h0,        32'h0},        // R3
    {1'b1, 4'd12, 12'h100, 32'hAAAA5555, 32'h0},        // R12
    {1'b0, 4'd12, 12'h100, 32'h0,        32'hAAAA5555}, // R12
    {1'b1, 4'd12, 12'h620, 32'h0BADF00D, 32'h0},        // R12
    {1'b0, 4'd12, 12'h620, 32'h0,        32'h0BADF00D}, // R12
    {1'b1, 4'd12, 12'h258, 32'h13579BDF, 32'h0},        // R12
    {1'b0, 4'd12, 12'h258, 32'h0,        32'h13579BDF}, // R12
    {1'b1, 4'd9,  12'h10C, 32'h00000000, 32'h0},        // R9 hole
    {1'b0, 4'd9,  12'h10C, 32'h0,        32'h0000003F}, // R9
    {1'b1, 4'd9,  12'h250, 32'hFFFFFFFF, 32'h0},        // R9 hole
    {1'b0, 4'd9,  12'h250, 32'h0,        32'h0},        // R9
    {1'b1, 4'd9,  12'h604, 32'h00000001, 32'h0},        // R9 hole
    {1'b0, 4'd9,  12'h604, 32'h0,        32'h0},        // R9
    {1'b0, 4'd9,  12'h700, 32'h0,        32'h0},        // R9 unmapped
    {1'b1, 4'd10, 12'h25C, 32'h00000000, 32'h0},        // R10
    {1'b0, 4'd10, 12'h25C, 32'h0,        32'h1},        // R10
    {1'b1, 4'd7,  12'h000, 32'hFFFFFFFE, 32'h0},        // R7
    {1'b0, 4'd7,  12'h000, 32'h0,        32'h0},        // R7
    {1'b1, 4'd7,  12'h000, 32'h00000003, 32'h0},        // R7
    {1'b0, 4'd7,  12'h000, 32'h0,        32'h1},        // R7
    {1'b0, 4'd4,  12'h004, 32'h0,        32'h0},        // R4
    {1'b0, 4'd4,  12'h008, 32'h0,        32'h0},        // R4
    {1'b1, 4'd3,  12'h00C, 32'h00000001, 32'h0},        // R3 write ignored
    {1'b0, 4'd3,  12'h00C, 32'h0,        32'h0},        // R3
    {1'b1, 4'd11, 12'h102, 32'h12345678, 32'h0},        // R11 unaligned
    {1'b0, 4'd11, 12'h100, 32'h0,        32'hAAAA5555}, // R11
    {1'b0, 4'd11, 12'h102, 32'h0,        32'h0},        // R11
    {1'b1, 4'd11, 12'h006, 32'h0000767B, 32'h0},        // R11 unaligned key
    {1'b0, 4'd11, 12'h00C, 32'h0,        32'h0},        // R11
    {1'b1, 4'd1,  12'h004, 32'h0000767A, 32'h0},        // R1 wrong key
    {1'b0, 4'd1,  12'h00C, 32'h0,        32'h0},        // R1
    {1'b1, 4'd1,  12'h004, 32'hABCD767B, 32'h0},        // R1 lock
    {1'b0, 4'd1,  12'h00C, 32'h0,        32'h1},        // R1
    {1'b1, 4'd6,  12'h620, 32'h00000000, 32'h0},        // R6 locked write
    {1'b0, 4'd6,  12'h620, 32'h0,        32'h0BADF00D}  // R6
  };

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    pulse_now = soft_rst_req;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    total = 0; bad = 0; pulse_now = 1'b0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    check({31'b0, soft_rst_req}, 32'h0, "R5 request low in reset");
    rst_n = 1'b1;

    // reset state, R5
    bus_read(12'h00C, r); check(r, 32'h1, "R5 lock after reset");
    bus_read(12'h10C, r); check(r, 32'h3F, "R5 status default");
    bus_read(12'h200, r); check(r, 32'h0, "R5 reset-control default");
    bus_read(12'h000, r); check(r, 32'h0, "R5 scratch default");

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][80]) begin
        bus_write(VEC[i][75:64], VEC[i][63:32]);
      end else begin
        bus_read(VEC[i][75:64], r);
        total++;
        if (r !== VEC[i][31:0]) begin
          bad++;
          $display("FAIL R%0d vec %0d addr=%h actual=%h expected=%h",
                   VEC[i][79:76], i, VEC[i][75:64], r, VEC[i][31:0]);
        end
      end
    end

    // R8 soft-reset pulse
    bus_write(12'h008, 32'h0000DF0D);
    bus_write(12'h200, 32'h00000002);
    check({31'b0, pulse_now}, 32'h0, "R8 no pulse when bit0 clear");
    bus_read(12'h200, r); check(r, 32'h2, "R12 reset-control stored");
    bus_write(12'h200, 32'h00000003);
    check({31'b0, pulse_now}, 32'h1, "R8 pulse after write");
    @(negedge clk);
    check({31'b0, soft_rst_req}, 32'h0, "R8 pulse one cycle");
    bus_write(12'h004, 32'h0000767B);
    bus_write(12'h200, 32'h00000001);
    check({31'b0, pulse_now}, 32'h0, "R8 no pulse when locked");
    bus_read(12'h200, r); check(r, 32'h3, "R6 reset-control held");

    // R5 reset during operation
    bus_write(12'h008, 32'h0000DF0D);
    bus_write(12'h100, 32'h5A5A5A5A);
    bus_write(12'h000, 32'h1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    bus_read(12'h00C, r); check(r, 32'h1, "R5 relocked by reset");
    bus_read(12'h100, r); check(r, 32'h0, "R5 storage cleared");
    bus_read(12'h000, r); check(r, 32'h0, "R5 scratch cleared");

    summary();
    $finish;
  end

endmodule